// File: doc/BRIEF.md
# Two-Level Interrupt Entry Controller

This block decides, cycle by cycle, whether the core takes an external interrupt at one of two fixed levels: critical and non-critical. It looks at two level-sensitive request lines, the core's current program counter and status word, a return strobe for each level, and a cause code. When a request is accepted it signals the take in the same cycle, supplies that level's handler address, and gives the core a new status word to load. It also captures the return address and old status in the save pair that belongs to the level.

Each level has its own save pair, so a critical interrupt can preempt a running non-critical handler without destroying that handler's saved context. A return strobe gives the core the program counter and status word from the matching pair. A syndrome register keeps the cause code of the most recent entry. The core owns the status register. It loads `status_nxt_o` whenever `status_load_o` is high, and loads `ret_pc_o` into its program counter whenever `pc_load_o` is high.

Top module: `irq_entry_ctrl`

## Requirements
- R1: If both requests are pending and both levels are enabled in the same cycle, the critical request is taken. `take_crit_o` is then 1.
- R2: A critical request is taken while a non-critical handler runs. In that state status bit 0 is 0 and bit 1 is 1.
- R3: Status bit 0 enables the non-critical level and status bit 1 enables the critical level. No other bit gates a take, and a request whose own enable bit is 0 is not taken.
- R4: On a non-critical take, the non-critical save pair captures `pc_i` and `status_i` at the clock edge.
- R5: On a critical take, the critical save pair captures `pc_i` and `status_i` at the clock edge, and the non-critical pair is left unchanged.
- R6: A return strobe drives `pc_load_o` and `status_load_o` high in the same cycle. `ret_pc_o` and `status_nxt_o` then carry the contents of that level's save pair. If both strobes are high, the critical pair is used.
- R7: `take_o` is combinational, in the cycle of acceptance. `vector_o` is `CRIT_VEC` for a critical take, `NORM_VEC` for a non-critical take, and zero when there is no take.
- R8: At the edge that ends a take cycle, the syndrome register captures `cause_i`.
- R9: On a take, `status_load_o` is 1. `status_nxt_o` equals `status_i` with bit 0 cleared for a non-critical take, or with bits 0 and 1 cleared for a critical take. All other bits are kept.
- R10: A request held high after a take, with the loaded status applied, produces no second take. With no take and no return, `status_load_o` and `pc_load_o` are 0.
- R11: After reset, all save registers and the syndrome register read zero.
- R12: In a cycle with any return strobe, no take occurs. A pending request is evaluated against the restored status in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crit_req_i | input | 1 | Critical request, level sensitive |
| norm_req_i | input | 1 | Non-critical request, level sensitive |
| pc_i | input | AW | Current program counter |
| status_i | input | SW | Current status word |
| cause_i | input | CW | Cause code for the syndrome |
| crit_ret_i | input | 1 | Return from critical handler |
| norm_ret_i | input | 1 | Return from non-critical handler |
| take_o | output | 1 | Interrupt accepted this cycle |
| take_crit_o | output | 1 | Accepted interrupt is critical |
| vector_o | output | AW | Handler address of the accepted level |
| status_load_o | output | 1 | Core loads `status_nxt_o` |
| status_nxt_o | output | SW | Status word to load |
| pc_load_o | output | 1 | Core loads `ret_pc_o` |
| ret_pc_o | output | AW | Restored program counter |
| nsave_pc_o | output | AW | Non-critical saved program counter |
| nsave_st_o | output | SW | Non-critical saved status |
| csave_pc_o | output | AW | Critical saved program counter |
| csave_st_o | output | SW | Critical saved status |
| syndrome_o | output | CW | Cause code of the last entry |

## Verification
The bench targets these corner cases, each with the failure it would expose:
- **Preemption:** a critical entry issued while the non-critical context is saved. A design that shares one save pair would overwrite the non-critical return address.
- **Simultaneous requests:** a design with inverted priority would vector to the non-critical handler.
- **Return and request in the same cycle:** a design that lets the request win would save a stale context and skip the restore.
- **Both return strobes high:** a design that decodes the strobes wrongly would restore from the wrong pair.
- **Held request after entry:** a request is held high after entry with the cleared status fed back. A design that fails to clear the enable bit would pulse `take_o` again.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int unsigned NUM_LVL  = 2;
  localparam int unsigned NORM_IDX = 0;
  localparam int unsigned CRIT_IDX = 1;
  localparam int unsigned NE_BIT   = 0;
  localparam int unsigned CE_BIT   = 1;

  // status enable bit owned by a level
  function automatic int unsigned en_bit(input int unsigned lvl);
    return (lvl == CRIT_IDX) ? CE_BIT : NE_BIT;
  endfunction
endpackage

// File: rtl/irq_entry_arb.sv
module irq_entry_arb #(
  parameter int unsigned NL = 2
) (
  input  logic [NL-1:0] req_i,
  input  logic [NL-1:0] en_i,
  input  logic [NL-1:0] ret_i,
  output logic          take_o,
  output logic [NL-1:0] take_lvl_o,
  output logic [NL-1:0] ret_lvl_o
);
  logic blk_take, blk_ret;

  // highest index wins; any return blocks a take
  always_comb begin
    blk_take   = |ret_i;
    blk_ret    = 1'b0;
    take_lvl_o = '0;
    ret_lvl_o  = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (!blk_take && req_i[i] && en_i[i]) begin
        take_lvl_o[i] = 1'b1;
        blk_take      = 1'b1;
      end
      if (!blk_ret && ret_i[i]) begin
        ret_lvl_o[i] = 1'b1;
        blk_ret      = 1'b1;
      end
    end
  end

  assign take_o = |take_lvl_o;
endmodule

// File: rtl/irq_save_pair.sv
module irq_save_pair #(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] pc_d_i,
  input  logic [SW-1:0] st_d_i,
  output logic [AW-1:0] pc_q_o,
  output logic [SW-1:0] st_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q_o <= '0;
      st_q_o <= '0;
    end else if (we_i) begin
      pc_q_o <= pc_d_i;
      st_q_o <= st_d_i;
    end
  end
endmodule

// File: rtl/irq_status_mux.sv
module irq_status_mux
  import irq_entry_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 8
) (
  input  logic [SW-1:0]      status_i,
  input  logic [NUM_LVL-1:0] take_lvl_i,
  input  logic [NUM_LVL-1:0] ret_lvl_i,
  input  logic [AW-1:0]      sv_pc_i [NUM_LVL],
  input  logic [SW-1:0]      sv_st_i [NUM_LVL],
  output logic [SW-1:0]      status_nxt_o,
  output logic [AW-1:0]      ret_pc_o
);
  always_comb begin
    status_nxt_o = status_i;
    ret_pc_o     = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      // entry masks its own level and every lower one
      if (take_lvl_i[l]) begin
        for (int k = 0; k <= l; k++) status_nxt_o[en_bit(k)] = 1'b0;
      end
    end
    for (int l = 0; l < NUM_LVL; l++) begin
      if (ret_lvl_i[l]) begin
        status_nxt_o = sv_st_i[l];
        ret_pc_o     = sv_pc_i[l];
      end
    end
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   SW       = 8,
  parameter int unsigned   CW       = 4,
  parameter logic [AW-1:0] CRIT_VEC = 32'h0000_0100,
  parameter logic [AW-1:0] NORM_VEC = 32'h0000_0500
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          crit_req_i,
  input  logic          norm_req_i,
  input  logic [AW-1:0] pc_i,
  input  logic [SW-1:0] status_i,
  input  logic [CW-1:0] cause_i,
  input  logic          crit_ret_i,
  input  logic          norm_ret_i,
  output logic          take_o,
  output logic          take_crit_o,
  output logic [AW-1:0] vector_o,
  output logic          status_load_o,
  output logic [SW-1:0] status_nxt_o,
  output logic          pc_load_o,
  output logic [AW-1:0] ret_pc_o,
  output logic [AW-1:0] nsave_pc_o,
  output logic [SW-1:0] nsave_st_o,
  output logic [AW-1:0] csave_pc_o,
  output logic [SW-1:0] csave_st_o,
  output logic [CW-1:0] syndrome_o
);
  logic [NUM_LVL-1:0] req, en, ret, take_lvl, ret_lvl;
  logic [AW-1:0]      sv_pc [NUM_LVL];
  logic [SW-1:0]      sv_st [NUM_LVL];
  logic [CW-1:0]      syn_q;

  always_comb begin
    req = '0;
    ret = '0;
    req[CRIT_IDX] = crit_req_i;
    req[NORM_IDX] = norm_req_i;
    ret[CRIT_IDX] = crit_ret_i;
    ret[NORM_IDX] = norm_ret_i;
    for (int l = 0; l < NUM_LVL; l++) en[l] = status_i[en_bit(l)];
  end

  irq_entry_arb #(.NL(NUM_LVL)) u_arb (
    .req_i      (req),
    .en_i       (en),
    .ret_i      (ret),
    .take_o     (take_o),
    .take_lvl_o (take_lvl),
    .ret_lvl_o  (ret_lvl)
  );

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    irq_save_pair #(.AW(AW), .SW(SW)) u_pair (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (take_lvl[g]),
      .pc_d_i (pc_i),
      .st_d_i (status_i),
      .pc_q_o (sv_pc[g]),
      .st_q_o (sv_st[g])
    );
  end

  irq_status_mux #(.AW(AW), .SW(SW)) u_mux (
    .status_i     (status_i),
    .take_lvl_i   (take_lvl),
    .ret_lvl_i    (ret_lvl),
    .sv_pc_i      (sv_pc),
    .sv_st_i      (sv_st),
    .status_nxt_o (status_nxt_o),
    .ret_pc_o     (ret_pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     syn_q <= '0;
    else if (take_o) syn_q <= cause_i;
  end

  assign take_crit_o   = take_lvl[CRIT_IDX];
  assign vector_o      = take_lvl[CRIT_IDX] ? CRIT_VEC :
                         take_lvl[NORM_IDX] ? NORM_VEC : '0;
  assign pc_load_o     = |ret_lvl;
  assign status_load_o = take_o | pc_load_o;
  assign nsave_pc_o    = sv_pc[NORM_IDX];
  assign nsave_st_o    = sv_st[NORM_IDX];
  assign csave_pc_o    = sv_pc[CRIT_IDX];
  assign csave_st_o    = sv_st[CRIT_IDX];
  assign syndrome_o    = syn_q;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int unsigned   AW       = 32,
  parameter int unsigned   SW       = 8,
  parameter int unsigned   CW       = 4,
  parameter logic [AW-1:0] CRIT_VEC = 32'h0000_0100,
  parameter logic [AW-1:0] NORM_VEC = 32'h0000_0500
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          crit_req_i,
  input logic          norm_req_i,
  input logic [AW-1:0] pc_i,
  input logic [SW-1:0] status_i,
  input logic [CW-1:0] cause_i,
  input logic          crit_ret_i,
  input logic          norm_ret_i,
  input logic          take_o,
  input logic          take_crit_o,
  input logic [AW-1:0] vector_o,
  input logic          status_load_o,
  input logic [SW-1:0] status_nxt_o,
  input logic          pc_load_o,
  input logic [AW-1:0] ret_pc_o,
  input logic [AW-1:0] nsave_pc_o,
  input logic [SW-1:0] nsave_st_o,
  input logic [AW-1:0] csave_pc_o,
  input logic [SW-1:0] csave_st_o,
  input logic [CW-1:0] syndrome_o
);
  logic any_ret;
  assign any_ret = crit_ret_i | norm_ret_i;

  p_crit_prio_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_req_i && status_i[1] && !any_ret) |-> (take_o && take_crit_o));

  p_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(crit_req_i && status_i[1]) && !(norm_req_i && status_i[0])) |-> !take_o);

  p_norm_save_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !take_crit_o) |=> (nsave_pc_o == $past(pc_i) && nsave_st_o == $past(status_i)));

  p_crit_keeps_norm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && take_crit_o) |=> ($stable(nsave_pc_o) && $stable(nsave_st_o)
                                 && csave_pc_o == $past(pc_i)));

  p_crit_ret_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_ret_i |-> (pc_load_o && status_load_o && ret_pc_o == csave_pc_o
                    && status_nxt_o == csave_st_o));

  p_vector_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vector_o == (take_crit_o ? CRIT_VEC : NORM_VEC)));

  p_syndrome_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (syndrome_o == $past(cause_i)));

  p_entry_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (status_load_o && !status_nxt_o[0]
                && (!take_crit_o || !status_nxt_o[1])));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_o && !any_ret) |-> (!status_load_o && !pc_load_o));

  p_ret_first_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ret |-> !take_o);
endmodule

bind irq_entry_ctrl irq_entry_chk #(
  .AW(AW), .SW(SW), .CW(CW), .CRIT_VEC(CRIT_VEC), .NORM_VEC(NORM_VEC)
) u_chk (.*);

// File: tb/tb_irq_entry_ctrl.sv
module tb_irq_entry_ctrl;
  localparam int unsigned AW = 32;
  localparam int unsigned SW = 8;
  localparam int unsigned CW = 4;
  localparam logic [AW-1:0] CV = 32'h0000_0100;
  localparam logic [AW-1:0] NV = 32'h0000_0500;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic crit_req_i = 0, norm_req_i = 0, crit_ret_i = 0, norm_ret_i = 0;
  logic [AW-1:0] pc_i = '0;
  logic [SW-1:0] status_i = '0;
  logic [CW-1:0] cause_i = '0;
  logic take_o, take_crit_o, status_load_o, pc_load_o;
  logic [AW-1:0] vector_o, ret_pc_o, nsave_pc_o, csave_pc_o;
  logic [SW-1:0] status_nxt_o, nsave_st_o, csave_st_o;
  logic [CW-1:0] syndrome_o;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] m_npc = '0, m_cpc = '0;
  logic [SW-1:0] m_nst = '0, m_cst = '0, e_nxt = '0;
  logic [CW-1:0] m_syn = '0;
  logic e_load = 0;

  always #10 clk_i = ~clk_i;

  irq_entry_ctrl #(.AW(AW), .SW(SW), .CW(CW), .CRIT_VEC(CV), .NORM_VEC(NV)) dut (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic cr, input logic nr, input logic crt,
                      input logic nrt, input logic [AW-1:0] pc, input logic [SW-1:0] st,
                      input logic [CW-1:0] cause);
    logic ret, ctk, tk;
    logic [AW-1:0] e_vec, e_rpc;
    @(negedge clk_i);
    crit_req_i = cr; norm_req_i = nr; crit_ret_i = crt; norm_ret_i = nrt;
    pc_i = pc; status_i = st; cause_i = cause;
    #2;
    ret   = crt | nrt;
    ctk   = !ret && cr && st[1];
    tk    = ctk || (!ret && nr && st[0]);
    e_vec = tk ? (ctk ? CV : NV) : '0;
    e_rpc = crt ? m_cpc : nrt ? m_npc : '0;
    e_nxt = crt ? m_cst : nrt ? m_nst : ctk ? (st & ~8'h03) : tk ? (st & ~8'h01) : st;
    e_load = tk | ret;
    chk(tag, "take", take_o, tk);
    chk(tag, "take_crit", take_crit_o, ctk);
    chk(tag, "vector", vector_o, e_vec);
    chk(tag, "status_load", status_load_o, e_load);
    chk(tag, "status_nxt", status_nxt_o, e_nxt);
    chk(tag, "pc_load", pc_load_o, ret);
    chk(tag, "ret_pc", ret_pc_o, e_rpc);
    @(posedge clk_i);
    if (ctk) begin m_cpc = pc; m_cst = st; end
    else if (tk) begin m_npc = pc; m_nst = st; end
    if (tk) m_syn = cause;
    #2;
    chk(tag, "nsave_pc", nsave_pc_o, m_npc);
    chk(tag, "nsave_st", nsave_st_o, m_nst);
    chk(tag, "csave_pc", csave_pc_o, m_cpc);
    chk(tag, "csave_st", csave_st_o, m_cst);
    chk(tag, "syndrome", syndrome_o, m_syn);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog R10 act=running exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [SW-1:0] st;
    void'($urandom(32'd2024));
    #35;
    // R11 reset state
    chk("R11", "nsave_pc", nsave_pc_o, 0);
    chk("R11", "csave_st", csave_st_o, 0);
    chk("R11", "syndrome", syndrome_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    step("R3", 0, 1, 0, 0, 32'h10, 8'h02, 4'h1);       // norm masked
    step("R3", 1, 0, 0, 0, 32'h14, 8'h01, 4'h2);       // crit masked
    step("R4", 0, 1, 0, 0, 32'h1000, 8'h83, 4'h5);     // norm entry, R7 R8 R9
    step("R2", 1, 1, 0, 0, 32'h1004, e_nxt, 4'h9);     // preempt, R5
    step("R10", 1, 1, 0, 0, 32'h0100, e_nxt, 4'h3);    // held req masked
    step("R6", 0, 0, 1, 0, 32'h0104, e_nxt, 4'h0);     // crit return
    step("R6", 0, 0, 0, 1, 32'h1004, e_nxt, 4'h0);     // norm return
    step("R1", 1, 1, 0, 0, 32'h2000, 8'h43, 4'hA);     // simultaneous
    step("R12", 1, 1, 1, 0, 32'h0100, 8'h40, 4'hB);    // return wins
    step("R12", 1, 1, 0, 0, 32'h2000, e_nxt, 4'hC);    // restored status
    step("R6", 0, 0, 1, 1, 32'h0100, 8'h00, 4'h0);     // both returns
    step("R9", 0, 1, 0, 0, 32'h3000, 8'hFD, 4'h7);     // upper bits kept

    st = 8'h03;
    for (int i = 0; i < 3000; i++) begin
      logic cr, nr, crt, nrt;
      cr  = ($urandom % 3) == 0;
      nr  = ($urandom % 2) == 0;
      crt = ($urandom % 9) == 0;
      nrt = ($urandom % 9) == 0;
      if (($urandom % 7) == 0) st = SW'($urandom);
      step("R10", cr, nr, crt, nrt, $urandom, st, CW'($urandom));
      if (e_load) st = e_nxt;
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule